// File: doc/BRIEF.md
# UART FIFO pair with DMA request pins

This block buffers bytes for one UART channel in two queues. The receive queue is filled by the deserializer and drained by the host. The transmit queue is filled by the host and drained by the serializer. Both queues use the same depth rule. In normal operation a queue counts as full at 32 bytes. When the extended-mode flag is set, it counts as full at 128 bytes. A write that arrives while a queue is full is discarded, and a sticky overflow flag is raised.

Two active-low request pins tell a DMA engine or the host when to move data. A single mode bit picks how both pins behave.

In level mode, each pin simply follows the fill state of its queue.

In burst mode, the receive pin falls once enough data has gathered, meaning the programmed trigger level or a timeout strobe. It then stays low until the queue has been drained completely. In the same mode, the transmit pin is raised only while the transmit queue is full.

A FIFO-clear input empties both queues and returns both pins to their idle values.

Top module: `uart_fifo_dma`

## Requirements
- R1: Bytes leave each queue in the order they were accepted. The read data port shows the oldest byte while the queue is non-empty. The level output equals the number of stored bytes and updates one clock after the access.
- R2: With ext_mode_i=0, each queue reports full at 32 bytes. A write while full is dropped, and the level does not change. A dropped write sets that queue's overflow flag, which stays set until cleared.
- R3: With ext_mode_i=1, each queue reports full at 128 bytes and accepts writes up to that count.
- R4: A read from an empty queue has no effect: the level stays 0 and empty stays 1.
- R5: With dma_mode_i=0, rx_req_no is 1 exactly when the receive queue is empty. In every mode, rx_req_no is 1 whenever the receive queue is empty.
- R6: With dma_mode_i=1, rx_req_no goes low when the receive level is at or above the trigger. A trigger value of 0 acts as 1. Once low, it stays low while bytes are read out, and returns to 1 only when the receive queue is empty.
- R7: With dma_mode_i=1, a cycle with rx_tmo_i=1 and a non-empty receive queue drives rx_req_no low, and it stays low until the queue empties. A timeout strobe while the queue is empty leaves rx_req_no at 1.
- R8: With dma_mode_i=0, tx_req_no is 0 when the transmit queue is empty and 1 when it holds at least one byte.
- R9: With dma_mode_i=1, tx_req_no is 1 exactly while the transmit queue is full. It returns to 0 one clock after a read frees a location.
- R10: After rst_ni, or one clock after fifo_clr_i, both queues are empty with level 0, both overflow flags are 0, rx_req_no=1 and tx_req_no=0.
- R11: A read and a write to the same non-empty queue in one cycle leave its level unchanged if it was not full. If it was full, the write is dropped and the level falls by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_clr_i | input | 1 | Synchronous clear of both queues |
| dma_mode_i | input | 1 | 1 selects burst-style request pins |
| ext_mode_i | input | 1 | 1 selects 128-byte full threshold, 0 selects 32 |
| rx_trig_i | input | 8 | Receive trigger level (0 treated as 1) |
| rx_tmo_i | input | 1 | Receive timeout strobe |
| rx_wr_i | input | 1 | Deserializer write strobe |
| rx_wdata_i | input | 8 | Deserializer write byte |
| rx_rd_i | input | 1 | Host read strobe |
| rx_rdata_o | output | 8 | Oldest receive byte |
| tx_wr_i | input | 1 | Host write strobe |
| tx_wdata_i | input | 8 | Host write byte |
| tx_rd_i | input | 1 | Serializer read strobe |
| tx_rdata_o | output | 8 | Oldest transmit byte |
| rx_level_o | output | 8 | Receive byte count |
| tx_level_o | output | 8 | Transmit byte count |
| rx_full_o | output | 1 | Receive queue full |
| rx_empty_o | output | 1 | Receive queue empty |
| tx_full_o | output | 1 | Transmit queue full |
| tx_empty_o | output | 1 | Transmit queue empty |
| rx_ovf_o | output | 1 | Sticky receive overflow |
| tx_ovf_o | output | 1 | Sticky transmit overflow |
| rx_req_no | output | 1 | Receive request, active low |
| tx_req_no | output | 1 | Transmit request, active low |

## Verification
A corrupted byte counter is the most visible internal fault. It shows at the level outputs one clock after the faulty access, and the full/empty flags and both request pins move with it in the same cycle. A wrong read pointer shows only when the next byte is presented at the read data port, which the scoreboard compares on every read. A stuck receive request latch stays hidden until the burst-mode pin either rises early while bytes are still being drained below the trigger, or stays low after the last byte leaves. That is why the drain sequences are checked byte by byte down to empty.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  typedef enum logic {
    REQ_LEVEL = 1'b0,
    REQ_BURST = 1'b1
  } req_style_e;

  function automatic req_style_e req_style(input logic dma);
    return dma ? REQ_BURST : REQ_LEVEL;
  endfunction
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned SMALL  = 32,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ext_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  level_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              ovf_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q, limit;
  logic              wr_ok, rd_ok;

  assign limit   = ext_i ? CNT_W'(DEPTH) : CNT_W'(SMALL);
  assign full_o  = (cnt_q >= limit);
  assign empty_o = (cnt_q == '0);
  assign wr_ok   = wr_i && !full_o;
  assign rd_ok   = rd_i && !empty_o;
  assign rdata_o = mem_q[rd_ptr_q];
  assign level_o = cnt_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_ok && !clr_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_o    <= 1'b0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_o    <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr_q <= bump(wr_ptr_q);
      if (rd_ok) rd_ptr_q <= bump(rd_ptr_q);
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (wr_i && full_o) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_req_gen.sv
module rx_req_gen
  import uart_fifo_pkg::*;
#(
  parameter int unsigned LVL_W  = 8,
  parameter int unsigned TRIG_W = 8,
  localparam int unsigned CMP_W = (LVL_W > TRIG_W) ? LVL_W : TRIG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  req_style_e        style_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [TRIG_W-1:0] trig_i,
  input  logic              tmo_i,
  output logic              req_no
);
  logic [TRIG_W-1:0] trig_eff;
  logic              has_data, hit, low_d, low_q;

  assign trig_eff = (trig_i == '0) ? TRIG_W'(1) : trig_i;
  assign has_data = (level_i != '0);
  assign hit      = CMP_W'(level_i) >= CMP_W'(trig_eff);
  // once asserted, held until the queue drains
  assign low_d    = has_data && (low_q || hit || tmo_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    low_q <= 1'b0;
    else if (clr_i) low_q <= 1'b0;
    else            low_q <= low_d;
  end

  assign req_no = (style_i == REQ_BURST) ? !low_d : !has_data;
endmodule

// File: rtl/tx_req_gen.sv
module tx_req_gen
  import uart_fifo_pkg::*;
(
  input  req_style_e style_i,
  input  logic       full_i,
  input  logic       empty_i,
  output logic       req_no
);
  assign req_no = (style_i == REQ_BURST) ? full_i : !empty_i;
endmodule

// File: rtl/uart_fifo_dma.sv
module uart_fifo_dma
  import uart_fifo_pkg::*;
#(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned SMALL  = 32,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TRIG_W = 8,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_clr_i,
  input  logic              dma_mode_i,
  input  logic              ext_mode_i,
  input  logic [TRIG_W-1:0] rx_trig_i,
  input  logic              rx_tmo_i,
  input  logic              rx_wr_i,
  input  logic [DATA_W-1:0] rx_wdata_i,
  input  logic              rx_rd_i,
  output logic [DATA_W-1:0] rx_rdata_o,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_wdata_i,
  input  logic              tx_rd_i,
  output logic [DATA_W-1:0] tx_rdata_o,
  output logic [LVL_W-1:0]  rx_level_o,
  output logic [LVL_W-1:0]  tx_level_o,
  output logic              rx_full_o,
  output logic              rx_empty_o,
  output logic              tx_full_o,
  output logic              tx_empty_o,
  output logic              rx_ovf_o,
  output logic              tx_ovf_o,
  output logic              rx_req_no,
  output logic              tx_req_no
);
  req_style_e style;
  assign style = req_style(dma_mode_i);

  byte_fifo #(.DEPTH(DEPTH), .SMALL(SMALL), .DATA_W(DATA_W)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (fifo_clr_i),
    .ext_i   (ext_mode_i),
    .wr_i    (rx_wr_i),
    .wdata_i (rx_wdata_i),
    .rd_i    (rx_rd_i),
    .rdata_o (rx_rdata_o),
    .level_o (rx_level_o),
    .full_o  (rx_full_o),
    .empty_o (rx_empty_o),
    .ovf_o   (rx_ovf_o)
  );

  byte_fifo #(.DEPTH(DEPTH), .SMALL(SMALL), .DATA_W(DATA_W)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (fifo_clr_i),
    .ext_i   (ext_mode_i),
    .wr_i    (tx_wr_i),
    .wdata_i (tx_wdata_i),
    .rd_i    (tx_rd_i),
    .rdata_o (tx_rdata_o),
    .level_o (tx_level_o),
    .full_o  (tx_full_o),
    .empty_o (tx_empty_o),
    .ovf_o   (tx_ovf_o)
  );

  rx_req_gen #(.LVL_W(LVL_W), .TRIG_W(TRIG_W)) u_rx_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (fifo_clr_i),
    .style_i (style),
    .level_i (rx_level_o),
    .trig_i  (rx_trig_i),
    .tmo_i   (rx_tmo_i),
    .req_no  (rx_req_no)
  );

  tx_req_gen u_tx_req (
    .style_i (style),
    .full_i  (tx_full_o),
    .empty_i (tx_empty_o),
    .req_no  (tx_req_no)
  );
endmodule

// File: rtl/uart_fifo_dma_chk.sv
module uart_fifo_dma_chk #(
  parameter int unsigned LVL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fifo_clr_i,
  input logic             dma_mode_i,
  input logic             rx_wr_i,
  input logic             rx_rd_i,
  input logic [LVL_W-1:0] rx_level_o,
  input logic             rx_full_o,
  input logic             rx_empty_o,
  input logic             rx_ovf_o,
  input logic             tx_full_o,
  input logic             tx_empty_o,
  input logic             tx_ovf_o,
  input logic             rx_req_no,
  input logic             tx_req_no
);
  p_push_count_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_clr_i && rx_wr_i && !rx_full_o && !rx_rd_i) |=> (rx_level_o == $past(rx_level_o) + 1'b1));

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_clr_i && rx_wr_i && rx_full_o && !rx_rd_i) |=> ($stable(rx_level_o) && rx_ovf_o));

  p_empty_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_clr_i && rx_empty_o && rx_rd_i && !rx_wr_i) |=> rx_empty_o);

  p_rx_first_byte_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dma_mode_i && !fifo_clr_i && rx_wr_i && rx_empty_o && !rx_rd_i) ##1 !dma_mode_i |-> !rx_req_no);

  p_rx_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_o |-> rx_req_no);

  p_rx_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_mode_i && !rx_req_no && !fifo_clr_i) ##1 (dma_mode_i && !rx_empty_o) |-> !rx_req_no);

  p_tx_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> !tx_req_no);

  p_tx_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_mode_i && tx_full_o) |-> tx_req_no);

  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clr_i |=> (rx_empty_o && tx_empty_o && rx_req_no && !tx_req_no && !rx_ovf_o && !tx_ovf_o));

  p_rdwr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_clr_i && rx_wr_i && rx_rd_i && !rx_empty_o && !rx_full_o) |=> $stable(rx_level_o));
endmodule

bind uart_fifo_dma uart_fifo_dma_chk #(.LVL_W(LVL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fifo_clr_i (fifo_clr_i),
  .dma_mode_i (dma_mode_i),
  .rx_wr_i    (rx_wr_i),
  .rx_rd_i    (rx_rd_i),
  .rx_level_o (rx_level_o),
  .rx_full_o  (rx_full_o),
  .rx_empty_o (rx_empty_o),
  .rx_ovf_o   (rx_ovf_o),
  .tx_full_o  (tx_full_o),
  .tx_empty_o (tx_empty_o),
  .tx_ovf_o   (tx_ovf_o),
  .rx_req_no  (rx_req_no),
  .tx_req_no  (tx_req_no)
);

// File: tb/uart_fifo_dma_tb.sv
`timescale 1ns/1ps
module uart_fifo_dma_tb;
  localparam int DEPTH = 128;
  localparam int SMALL = 32;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fifo_clr_i = 1'b0, dma_mode_i = 1'b0, ext_mode_i = 1'b0;
  logic [7:0] rx_trig_i = 8'd0;
  logic       rx_tmo_i = 1'b0;
  logic       rx_wr_i = 1'b0, rx_rd_i = 1'b0, tx_wr_i = 1'b0, tx_rd_i = 1'b0;
  logic [7:0] rx_wdata_i = '0, tx_wdata_i = '0;
  logic [7:0] rx_rdata_o, tx_rdata_o, rx_level_o, tx_level_o;
  logic       rx_full_o, rx_empty_o, tx_full_o, tx_empty_o, rx_ovf_o, tx_ovf_o;
  logic       rx_req_no, tx_req_no;

  uart_fifo_dma u_dut (.*);

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  int m_rx = 0, m_tx = 0, m_trig = 0;
  bit m_rxo = 0, m_txo = 0, m_low = 0, m_dma = 0, m_ext = 0;
  logic [7:0] rxq[$], txq[$];

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int lim();
    return m_ext ? DEPTH : SMALL;
  endfunction

  function automatic int trig_eff();
    return (m_trig == 0) ? 1 : m_trig;
  endfunction

  task automatic check_all();
    int rx_exp, tx_exp;
    chk("R1", "rx level", rx_level_o, m_rx);
    chk("R1", "tx level", tx_level_o, m_tx);
    chk(m_ext ? "R3" : "R2", "rx full", rx_full_o, m_rx >= lim());
    chk(m_ext ? "R3" : "R2", "tx full", tx_full_o, m_tx >= lim());
    chk("R4", "rx empty", rx_empty_o, m_rx == 0);
    chk("R4", "tx empty", tx_empty_o, m_tx == 0);
    chk("R2", "rx ovf", rx_ovf_o, m_rxo);
    chk("R2", "tx ovf", tx_ovf_o, m_txo);
    rx_exp = m_dma ? !(m_rx != 0 && (m_low || m_rx >= trig_eff())) : (m_rx == 0);
    tx_exp = m_dma ? (m_tx >= lim()) : (m_tx != 0);
    chk(m_dma ? "R6" : "R5", "rx req", rx_req_no, rx_exp);
    chk(m_dma ? "R9" : "R8", "tx req", tx_req_no, tx_exp);
  endtask

  // driver + scoreboard monitor; called just after a rising edge
  task automatic step(bit rw, logic [7:0] rd_d, bit rr, bit tw, logic [7:0] td, bit tr,
                      bit tmo, bit clr);
    int  rx_pre, tx_pre;
    bit  rwa, rra, twa, tra;
    dma_mode_i = m_dma; ext_mode_i = m_ext; rx_trig_i = 8'(m_trig);
    rx_wr_i = rw; rx_wdata_i = rd_d; rx_rd_i = rr;
    tx_wr_i = tw; tx_wdata_i = td; tx_rd_i = tr;
    rx_tmo_i = tmo; fifo_clr_i = clr;
    rx_pre = m_rx; tx_pre = m_tx;
    rwa = rw && m_rx < lim(); rra = rr && m_rx > 0;
    twa = tw && m_tx < lim(); tra = tr && m_tx > 0;
    #0.5;
    if (!clr && rra) chk("R1", "rx data", rx_rdata_o, rxq[0]);
    if (!clr && tra) chk("R1", "tx data", tx_rdata_o, txq[0]);
    @(posedge clk_i); #1;
    rx_wr_i = 0; rx_rd_i = 0; tx_wr_i = 0; tx_rd_i = 0; rx_tmo_i = 0; fifo_clr_i = 0;
    if (clr) begin
      m_rx = 0; m_tx = 0; m_rxo = 0; m_txo = 0; m_low = 0;
      rxq.delete(); txq.delete();
    end else begin
      m_low = (rx_pre != 0) && (m_low || rx_pre >= trig_eff() || tmo);
      if (rra) void'(rxq.pop_front());
      if (rwa) rxq.push_back(rd_d);
      if (rw && !rwa) m_rxo = 1;
      m_rx = m_rx + int'(rwa) - int'(rra);
      if (tra) void'(txq.pop_front());
      if (twa) txq.push_back(td);
      if (tw && !twa) m_txo = 1;
      m_tx = m_tx + int'(twa) - int'(tra);
    end
    check_all();
  endtask

  task automatic rx_put(logic [7:0] d); step(1, d, 0, 0, 0, 0, 0, 0); endtask
  task automatic rx_get();              step(0, 0, 1, 0, 0, 0, 0, 0); endtask
  task automatic tx_put(logic [7:0] d); step(0, 0, 0, 1, d, 0, 0, 0); endtask
  task automatic tx_get();              step(0, 0, 0, 0, 0, 1, 0, 0); endtask
  task automatic clear();               step(0, 0, 0, 0, 0, 0, 0, 1); endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    #1;
    // R10 reset state
    chk("R10", "rx req after reset", rx_req_no, 1);
    chk("R10", "tx req after reset", tx_req_no, 0);
    chk("R10", "rx level after reset", rx_level_o, 0);
    chk("R10", "tx empty after reset", tx_empty_o, 1);
    @(posedge clk_i); #1;

    // level mode traffic: R1 R5 R8
    for (int i = 0; i < 3; i++) rx_put(8'h10 + 8'(i));
    for (int i = 0; i < 3; i++) tx_put(8'hA0 + 8'(i));
    for (int i = 0; i < 3; i++) begin rx_get(); tx_get(); end

    // R7 timeout in burst mode
    m_dma = 1; m_trig = 10;
    step(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R7", "tmo on empty", rx_req_no, 1);
    rx_put(8'h55);
    chk("R7", "below trig no tmo", rx_req_no, 1);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R7", "tmo with data", rx_req_no, 0);
    rx_put(8'h56);
    chk("R7", "held after tmo", rx_req_no, 0);
    rx_get(); rx_get();
    chk("R7", "released when empty", rx_req_no, 1);

    // R6 trigger and hold while draining
    m_trig = 4;
    for (int i = 0; i < 4; i++) rx_put(8'h20 + 8'(i));
    chk("R6", "at trigger", rx_req_no, 0);
    for (int i = 0; i < 3; i++) rx_get();
    chk("R6", "held below trigger", rx_req_no, 0);
    rx_get();
    chk("R6", "released when empty", rx_req_no, 1);
    m_trig = 0;
    rx_put(8'h31);
    chk("R6", "trigger 0 acts as 1", rx_req_no, 0);
    rx_get();

    // R2 normal full and overflow, R4 empty read
    m_dma = 0;
    for (int i = 0; i < SMALL + 2; i++) rx_put(8'(i * 3));
    chk("R2", "rx level capped", rx_level_o, SMALL);
    chk("R2", "rx ovf set", rx_ovf_o, 1);
    for (int i = 0; i < SMALL + 1; i++) rx_get();
    chk("R4", "empty read keeps 0", rx_level_o, 0);

    // R11 simultaneous access
    rx_put(8'h71); rx_put(8'h72);
    step(1, 8'h73, 1, 0, 0, 0, 0, 0);
    chk("R11", "rd+wr level", rx_level_o, 2);
    for (int i = 0; i < SMALL - 2; i++) rx_put(8'(i + 1));
    step(1, 8'hEE, 1, 0, 0, 0, 0, 0);
    chk("R11", "rd+wr when full", rx_level_o, SMALL - 1);

    // R10 clear with content
    tx_put(8'h42);
    clear();
    chk("R10", "rx level after clear", rx_level_o, 0);
    chk("R10", "rx ovf after clear", rx_ovf_o, 0);
    chk("R10", "tx req after clear", tx_req_no, 0);

    // R3 extended depth, R9 burst transmit request
    m_ext = 1; m_dma = 1;
    for (int i = 0; i < DEPTH + 1; i++) tx_put(8'(i ^ 8'h5A));
    chk("R3", "tx level ext", tx_level_o, DEPTH);
    chk("R9", "tx req full", tx_req_no, 1);
    tx_get();
    chk("R9", "tx req one free", tx_req_no, 0);
    for (int i = 0; i < DEPTH - 1; i++) tx_get();
    chk("R3", "tx drained", tx_empty_o, 1);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule